// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. The stream arrives on three wires: a bit clock, a channel-select line and a data line. Left and right words share the data line in turns. All three wires come from an external master, and the block only listens. A two-bit format input picks one of two framings. The first is I2S-style framing, where the MSB comes one bit clock after the channel-select change and the word may be any length. The second is right-aligned framing of 16, 18 or 20 bits, where the LSB is the last bit before the channel-select change.

The block samples the serial lines with its own faster system clock. It finds bit-clock rising edges and places each sampled bit into a word for the correct channel. Each finished word is then aligned to a fixed 20-bit result. Right-aligned words are sign-extended. I2S words are placed in the top bits and padded with zeros. When a right-channel word completes, the block presents the stored left sample and the new right sample together, with a single-cycle valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, `pair_valid` is 0 and both sample outputs are 0 until the first pair is delivered.
- R2: With `fmt` = 2'b01, the 16 bits sampled on the last 16 bit-clock rising edges before a channel-select change form the word, MSB first. The word is sign-extended from bit 15 to 20 bits.
- R3: With `fmt` = 2'b10, the last 18 bits before the channel-select change form the word. The word is sign-extended from bit 17.
- R4: With `fmt` = 2'b11, the last 20 bits before the channel-select change form the word, unchanged.
- R5: In the right-aligned formats (`fmt` ≠ 2'b00), bits sent before the last N bits of a slot have no effect on the delivered sample, whatever their values.
- R6: With `fmt` = 2'b00, the bit sampled on the first rising edge after a channel-select change is the MSB of the new word. The last bit of a word is sampled on the edge at which channel select already shows the next channel. A 20-bit word is delivered unchanged, including when the slot is exactly 20 bits long.
- R7: With `fmt` = 2'b00, a word shorter than 20 bits occupies the top bits of the output, and the lower bits are 0.
- R8: With `fmt` = 2'b00, a word longer than 20 bits delivers its first 20 bits. Later bits are dropped.
- R9: Channel select low carries the left word and high carries the right word. Exactly one single-cycle `pair_valid` pulse occurs per stereo frame, after the right word completes. It presents that frame's left and right samples together.
- R10: Without bit-clock rising edges, nothing changes: no strobe occurs and the outputs hold, whatever the channel-select and data lines do. Outputs change only in a cycle with `pair_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Framing select: 00 I2S, 01/10/11 right-aligned 16/18/20 bits |
| bck | input | 1 | Serial bit clock from the external master |
| ws | input | 1 | Channel select, low = left, high = right |
| sd | input | 1 | Serial data, MSB first |
| left_out | output | 20 | Left sample of the last completed frame |
| right_out | output | 20 | Right sample of the last completed frame |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions check properties that must hold on every cycle. The strobe is never longer than one cycle. Each strobe follows a detected bit-clock edge at fixed latency. The outputs hold whenever the strobe is low. In the 16- and 18-bit formats, every delivered sample is properly sign-extended. Only the bench's directed frames can show that the right bits land in the right place. These cover the one-bit offset of I2S framing, left-justification of short words and truncation of long ones, and the end-of-slot selection that ignores idle bits. They also cover correct pairing of left and right samples and the state surviving a stretch with no bit clock.

// File: rtl/serial_audio_rx_pkg.sv
`timescale 1ns/1ps
package serial_audio_rx_pkg;
    typedef enum logic [1:0] {
        FMT_I2S   = 2'b00,
        FMT_RJ_A  = 2'b01,
        FMT_RJ_B  = 2'b10,
        FMT_RJ_C  = 2'b11
    } fmt_e;
endpackage

// File: rtl/serial_audio_rx_sync.sv
`timescale 1ns/1ps
// Brings the external serial lines into the system clock domain and
// produces a one-cycle strobe per bit-clock rising edge.
module serial_audio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic bit_stb,
    output logic ws_s,
    output logic sd_s
);
    typedef struct packed {
        logic [STAGES-1:0] bck;
        logic [STAGES-1:0] ws;
        logic [STAGES-1:0] sd;
        logic              bck_last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.bck      = {st_q.bck[STAGES-2:0], bck_in};
        st_d.ws       = {st_q.ws[STAGES-2:0],  ws_in};
        st_d.sd       = {st_q.sd[STAGES-2:0],  sd_in};
        st_d.bck_last = st_q.bck[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_stb = st_q.bck[STAGES-1] & ~st_q.bck_last;
    assign ws_s    = st_q.ws[STAGES-1];
    assign sd_s    = st_q.sd[STAGES-1];
endmodule

// File: rtl/serial_audio_rx_assembler.sv
`timescale 1ns/1ps
// Collects bits per channel. In I2S framing the channel a bit belongs to is
// the select value one edge earlier, so both framings reduce to "word ends
// when the effective channel changes, before the current bit".
module serial_audio_rx_assembler
    import serial_audio_rx_pkg::*;
#(
    parameter int W  = 20,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fmt_e          fmt,
    input  logic          bit_stb,
    input  logic          ws_s,
    input  logic          sd_s,
    output logic          done,
    output logic          done_ch,
    output logic [W-1:0]  done_bits,
    output logic [CW-1:0] done_cnt
);
    typedef struct packed {
        logic          ws_p1;
        logic          ch;
        logic          primed;
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
        logic          done;
        logic          done_ch;
        logic [W-1:0]  done_bits;
        logic [CW-1:0] done_cnt;
    } asm_t;

    asm_t st_d, st_q;
    logic is_i2s;
    logic ch_now;

    assign is_i2s = (fmt == FMT_I2S);
    assign ch_now = is_i2s ? st_q.ws_p1 : ws_s;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (bit_stb) begin
            if (st_q.primed && (ch_now != st_q.ch)) begin
                st_d.done      = 1'b1;
                st_d.done_ch   = st_q.ch;
                st_d.done_bits = st_q.sr;
                st_d.done_cnt  = st_q.cnt;
                st_d.sr        = W'(sd_s);
                st_d.cnt       = CW'(1);
            end else if (!is_i2s || (st_q.cnt < CW'(W))) begin
                // right-aligned keeps the newest bits, I2S keeps the first W
                st_d.sr = {st_q.sr[W-2:0], sd_s};
                if (st_q.cnt < CW'(W)) st_d.cnt = st_q.cnt + CW'(1);
            end
            st_d.ws_p1  = ws_s;
            st_d.ch     = ch_now;
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign done_ch   = st_q.done_ch;
    assign done_bits = st_q.done_bits;
    assign done_cnt  = st_q.done_cnt;
endmodule

// File: rtl/serial_audio_rx_align.sv
`timescale 1ns/1ps
// Maps a raw received word onto the fixed output width.
module serial_audio_rx_align
    import serial_audio_rx_pkg::*;
#(
    parameter int W     = 20,
    parameter int LEN_A = 16,
    parameter int LEN_B = 18,
    parameter int LEN_C = 20,
    parameter int CW    = $clog2(W + 1)
) (
    input  fmt_e          fmt,
    input  logic [W-1:0]  bits,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  word
);
    localparam int SH_A = W - LEN_A;
    localparam int SH_B = W - LEN_B;
    localparam int SH_C = W - LEN_C;

    logic signed [W-1:0] up_a, up_b, up_c;
    logic        [CW-1:0] pad;

    assign up_a = bits << SH_A;
    assign up_b = bits << SH_B;
    assign up_c = bits << SH_C;
    assign pad  = CW'(W) - cnt;

    always_comb begin
        case (fmt)
            FMT_RJ_A: word = up_a >>> SH_A;
            FMT_RJ_B: word = up_b >>> SH_B;
            FMT_RJ_C: word = up_c >>> SH_C;
            default:  word = bits << pad;
        endcase
    end
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
    import serial_audio_rx_pkg::*;
#(
    parameter int W           = 20,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   fmt,
    input  logic         bck,
    input  logic         ws,
    input  logic         sd,
    output logic [W-1:0] left_out,
    output logic [W-1:0] right_out,
    output logic         pair_valid
);
    typedef struct packed {
        logic [W-1:0] left_hold;
        logic [W-1:0] left_out;
        logic [W-1:0] right_out;
        logic         valid;
    } top_t;

    fmt_e          fmt_sel;
    logic          bit_stb, ws_s, sd_s;
    logic          done, done_ch;
    logic [W-1:0]  done_bits, word;
    logic [CW-1:0] done_cnt;
    top_t          st_d, st_q;

    assign fmt_sel = fmt_e'(fmt);

    serial_audio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bck_in(bck), .ws_in(ws), .sd_in(sd),
        .bit_stb(bit_stb), .ws_s(ws_s), .sd_s(sd_s)
    );

    serial_audio_rx_assembler #(.W(W)) u_asm (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_sel), .bit_stb(bit_stb),
        .ws_s(ws_s), .sd_s(sd_s), .done(done), .done_ch(done_ch),
        .done_bits(done_bits), .done_cnt(done_cnt)
    );

    serial_audio_rx_align #(.W(W)) u_align (
        .fmt(fmt_sel), .bits(done_bits), .cnt(done_cnt), .word(word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (done) begin
            if (!done_ch) begin
                st_d.left_hold = word;
            end else begin
                st_d.left_out  = st_q.left_hold;
                st_d.right_out = word;
                st_d.valid     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_out   = st_q.left_out;
    assign right_out  = st_q.right_out;
    assign pair_valid = st_q.valid;
endmodule

// File: rtl/serial_audio_rx_checker.sv
`timescale 1ns/1ps
module serial_audio_rx_checker #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   fmt,
    input logic         bit_stb,
    input logic [W-1:0] left_out,
    input logic [W-1:0] right_out,
    input logic         pair_valid
);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    assert_edge_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(bit_stb, 2));

    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

    assert_sext16_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && fmt == 2'b01) |->
        ((left_out[W-1:15] == '0 || left_out[W-1:15] == '1) &&
         (right_out[W-1:15] == '0 || right_out[W-1:15] == '1)));

    assert_sext18_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && fmt == 2'b10) |->
        ((left_out[W-1:17] == '0 || left_out[W-1:17] == '1) &&
         (right_out[W-1:17] == '0 || right_out[W-1:17] == '1)));
endmodule

bind serial_audio_rx serial_audio_rx_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bit_stb(bit_stb),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
);

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n, bck, ws, sd;
    logic [1:0]  fmt;
    logic [19:0] left_out, right_out;
    logic        pair_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int vcnt    = 0;

    logic [19:0] got_l, got_r;
    logic        pend_bit;
    bit          exp_valid;
    logic [19:0] exp_l, exp_r;
    string       exp_tag;

    always #2.5 clk = ~clk;

    serial_audio_rx u_serial_audio_rx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .bck(bck), .ws(ws), .sd(sd),
        .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
    );

    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            vcnt  <= vcnt + 1;
            got_l <= left_out;
            got_r <= right_out;
        end
    end

    task automatic check20(input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_rj(input logic [31:0] raw, input int n);
        logic [19:0] e;
        for (int i = 0; i < 20; i++) e[i] = (i < n) ? raw[i] : raw[n-1];
        return e;
    endfunction

    function automatic logic [19:0] exp_i2s(input logic [31:0] raw, input int nb);
        logic [19:0] e = '0;
        for (int k = 0; k < 20; k++) if (k < nb) e[19-k] = raw[nb-1-k];
        return e;
    endfunction

    task automatic send_bit(input logic w, input logic d);
        bck = 1'b0; ws = w; sd = d;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_slot(input logic ch, input logic [31:0] w, input int nb,
                             input int slot, input bit junk);
        for (int j = 0; j < slot; j++) begin
            logic b;
            if (fmt == 2'b00) begin
                if (j == 0)       b = pend_bit;
                else if (j <= nb) b = w[nb-j];
                else              b = 1'b0;
            end else begin
                if (j < slot - nb) b = junk ? ~w[nb-1] ^ j[0] : w[nb-1];
                else               b = w[slot-1-j];
            end
            send_bit(ch, b);
        end
        if (fmt == 2'b00) pend_bit = (nb == slot) ? w[0] : 1'b0;
    endtask

    // Sends one frame; checks the previous frame's pair during the left slot.
    task automatic send_frame(input string tag, input logic [31:0] l, input logic [31:0] r,
                              input int nb, input int slot, input bit junk, input bit chk);
        int base = vcnt;
        send_slot(1'b0, l, nb, slot, junk);
        if (exp_valid) begin
            check_int({exp_tag, " R9 one strobe per frame"}, vcnt - base, 1);
            check20({exp_tag, " left"}, got_l, exp_l);
            check20({exp_tag, " right"}, got_r, exp_r);
        end
        send_slot(1'b1, r, nb, slot, junk);
        exp_valid = chk;
        exp_tag   = tag;
        exp_l     = (fmt == 2'b00) ? exp_i2s(l, nb) : exp_rj(l, nb);
        exp_r     = (fmt == 2'b00) ? exp_i2s(r, nb) : exp_rj(r, nb);
    endtask

    task automatic start(input logic [1:0] f);
        rst_n = 1'b0; fmt = f; bck = 1'b0; ws = 1'b0; sd = 1'b0;
        pend_bit = 1'b0; exp_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; fmt = 2'b01; bck = 1'b0; ws = 1'b1; sd = 1'b1;
        repeat (3) @(negedge clk);
        check_int("R1 strobe in reset", int'(pair_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_int("R1 strobe after reset", int'(pair_valid), 0);
        check20("R1 left after reset", left_out, 20'h0);
        check20("R1 right after reset", right_out, 20'h0);
    endtask

    task automatic t_rj16;
        start(2'b01);
        send_frame("dummy", 0, 0, 16, 24, 0, 0);
        send_frame("R2 neg/pos", 32'h8001, 32'h7FFE, 16, 24, 0, 1);
        send_frame("R2 all ones", 32'hFFFF, 32'h0001, 16, 24, 0, 1);
        send_frame("flush", 0, 0, 16, 24, 0, 0);
    endtask

    task automatic t_rj18;
        start(2'b10);
        send_frame("dummy", 0, 0, 18, 24, 0, 0);
        send_frame("R3 min/pos", 32'h20000, 32'h1ABCD, 18, 24, 0, 1);
        send_frame("R3 mixed", 32'h3F00F, 32'h00001, 18, 24, 0, 1);
        send_frame("flush", 0, 0, 18, 24, 0, 0);
    endtask

    task automatic t_rj20;
        start(2'b11);
        send_frame("dummy", 0, 0, 20, 32, 0, 0);
        send_frame("R4 extremes", 32'h80000, 32'h7FFFF, 20, 32, 0, 1);
        send_frame("R4 pattern", 32'hA5A5A, 32'h5A5A5, 20, 32, 0, 1);
        send_frame("flush", 0, 0, 20, 32, 0, 0);
    endtask

    task automatic t_idle_junk;
        start(2'b01);
        send_frame("dummy", 0, 0, 16, 32, 1, 0);
        send_frame("R5 junk idle", 32'h1234, 32'hC3A5, 16, 32, 1, 1);
        send_frame("R5 junk idle 2", 32'hFFFE, 32'h0000, 16, 32, 1, 1);
        send_frame("flush", 0, 0, 16, 32, 0, 0);
    endtask

    task automatic t_i2s20;
        start(2'b00);
        send_frame("dummy", 0, 0, 20, 32, 0, 0);
        send_frame("R6 20-bit", 32'hA5C3E, 32'h5A3C1, 20, 32, 0, 1);
        send_frame("flush", 0, 0, 20, 32, 0, 0);
        start(2'b00);
        send_frame("dummy", 0, 0, 20, 20, 0, 0);
        send_frame("R6 full slot", 32'hFEDCB, 32'h12345, 20, 20, 0, 1);
        send_frame("R6 full slot 2", 32'h80001, 32'h00003, 20, 20, 0, 1);
        send_frame("flush", 0, 0, 20, 20, 0, 0);
    endtask

    task automatic t_i2s16;
        start(2'b00);
        send_frame("dummy", 0, 0, 16, 32, 0, 0);
        send_frame("R7 16-bit", 32'hBEEF, 32'h8001, 16, 32, 0, 1);
        send_frame("flush", 0, 0, 16, 32, 0, 0);
    endtask

    task automatic t_i2s24;
        start(2'b00);
        send_frame("dummy", 0, 0, 24, 32, 0, 0);
        send_frame("R8 24-bit", 32'hABCDEF, 32'h123456, 24, 32, 0, 1);
        send_frame("flush", 0, 0, 24, 32, 0, 0);
    endtask

    task automatic t_no_clock;
        logic [19:0] l0, r0;
        int base;
        start(2'b01);
        send_frame("dummy", 0, 0, 16, 24, 0, 0);
        send_frame("R10 before", 32'h4321, 32'h9876, 16, 24, 0, 1);
        send_frame("R10 pre-pause", 32'h0F0F, 32'hF0F0, 16, 24, 0, 1);
        l0 = left_out; r0 = right_out; base = vcnt;
        bck = 1'b1;
        for (int i = 0; i < 60; i++) begin
            ws = i[1]; sd = i[0];
            repeat (3) @(negedge clk);
        end
        ws = 1'b1;
        repeat (4) @(negedge clk);
        check_int("R10 no strobe without bit clock", vcnt - base, 0);
        check20("R10 left held", left_out, l0);
        check20("R10 right held", right_out, r0);
        // previous frame's pair must still come out intact after the pause
        send_frame("R10 after", 32'h7777, 32'h8888, 16, 24, 0, 1);
        send_frame("flush", 0, 0, 16, 24, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rj16();
        t_rj18();
        t_rj20();
        t_idle_junk();
        t_i2s20();
        t_i2s16();
        t_i2s24();
        t_no_clock();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule